// File: doc/BRIEF.md
# Clock-Loss Power-Down Controller

This block decides when the device is powered down and which of its channels are enabled. A sample clock is watched against a free-running reference tick. The sample clock arrives as a plain level. It passes through a two-flop synchroniser, and its rising edges are counted over a window of a fixed number of reference ticks. When a window closes with fewer edges than a set minimum, the clock is flagged as lost. The minimum is chosen to match the lowest allowed sample frequency. A stopped clock and a clock that runs too slowly are both caught this way. The flag clears by itself after a later window reaches the minimum again.

The global power-down output is raised by the external power-down pin, or by a lost clock while the detector is enabled. A single configuration register, written through a simple write port, holds two things: a detector-disable bit and one power-down bit per channel. Each channel's power-down output is the global power-down ORed with that channel's bit. The clock-lost flag stays visible as status even while the detector is disabled. Reset returns every register to zero, which is the inactive state.

Top module: `clkloss_pwrdn_ctrl`

## Requirements
- R1: While `pd_pin` is high, `pd_global` and every bit of `pd_ch` are high in the same cycle, whatever the register settings.
- R2: `clk_lost` changes value only in the cycle after a window ends. A window ends on the `ref_tick` pulse that completes WIN_TICKS ticks. At that point `clk_lost` is set if fewer than MIN_EDGES synchronised rising edges of `mon_clk` were counted in the window, and cleared otherwise.
- R3: A `mon_clk` that stays constant is reported as lost, with `clk_lost` = 1, from the first window that closes after it stops.
- R4: A window with exactly MIN_EDGES or more edges clears `clk_lost`. With the defaults, a `mon_clk` period of 8 cycles or shorter at 4-cycle tick spacing is not lost.
- R5: While the detector is enabled (config bit 0 = 0), `clk_lost` = 1 drives `pd_global` high.
- R6: With config bit 0 = 1, loss of clock has no effect on `pd_global` or `pd_ch`, and `clk_lost` still reports the detector result.
- R7: Config bit i+1 powers down channel i alone (`pd_ch[i]`) and leaves the other channels unaffected.
- R8: `pd_ch[i]` is the OR of `pd_global` and config bit i+1.
- R9: After reset the configuration register, `clk_lost` and all counters are 0. With `pd_pin` low, this gives `pd_global` = 0 and `pd_ch` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mon_clk | input | 1 | Monitored sample clock, sampled as a level |
| ref_tick | input | 1 | One-cycle pulse from the reference oscillator |
| pd_pin | input | 1 | External power-down request, active high |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | NUM_CH+1 | Bit 0 disables the detector; bit i+1 powers down channel i |
| pd_global | output | 1 | Global power-down |
| pd_ch | output | NUM_CH | Per-channel power-down |
| clk_lost | output | 1 | Clock-lost status |

## Verification
The assertions check on every cycle the invariants that need no history: the pin forces power-down, an enabled loss forces power-down, and a disabled detector with the pin low never does. They also check that global power-down covers all channels, that the edge counter stays bounded, and that `clk_lost` moves only in the cycle after a window end. Only the bench scenarios can show that a given frequency is classed correctly. These cover a stopped clock, a slow clock, a fast clock and a clock sitting exactly at the minimum, together with recovery after loss and the status staying visible while the detector is disabled.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;
  // Saturating increment of the edge count; limit keeps the counter narrow.
  function automatic int edge_next(input int cnt, input logic rise, input int lim);
    int n;
    n = cnt + (rise ? 1 : 0);
    return (n > lim) ? lim : n;
  endfunction

  // Window verdict: lost when the edges seen (including one arriving now) miss the minimum.
  function automatic logic window_short(input int cnt, input logic rise, input int lim);
    return edge_next(cnt, rise, lim) < lim;
  endfunction
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  output logic mon_rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= mon_clk;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign mon_rise = s2 & ~s3;
endmodule

// File: rtl/clkmon_window.sv
module clkmon_window #(
  parameter int WIN_TICKS = 8,
  parameter int MIN_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic mon_rise,
  output logic win_end,
  output logic clk_lost
);
  import clkloss_pkg::*;

  localparam int TICK_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
  localparam int EDGE_W = $clog2(MIN_EDGES + 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(WIN_TICKS - 1);

  logic [TICK_W-1:0] tick_cnt;
  logic [EDGE_W-1:0] edge_cnt;

  assign win_end = ref_tick && (tick_cnt == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      edge_cnt <= '0;
      clk_lost <= 1'b0;
    end else if (win_end) begin
      clk_lost <= window_short(int'(edge_cnt), mon_rise, MIN_EDGES);
      tick_cnt <= '0;
      edge_cnt <= '0;
    end else begin
      if (ref_tick) tick_cnt <= tick_cnt + 1'b1;
      edge_cnt <= EDGE_W'(edge_next(int'(edge_cnt), mon_rise, MIN_EDGES));
    end
  end

  // R2: the flag only moves right after a window boundary
  assert_lost_only_at_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(clk_lost));

  // R2: edge counter saturates at the minimum
  assert_edge_cnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(edge_cnt) <= MIN_EDGES);
endmodule

// File: rtl/pd_cfg_reg.sv
module pd_cfg_reg #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [NUM_CH:0]   wr_data,
  output logic              det_dis,
  output logic [NUM_CH-1:0] ch_off
);
  logic [NUM_CH:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= wr_data;
  end

  assign det_dis = cfg_q[0];
  assign ch_off  = cfg_q[NUM_CH:1];
endmodule

// File: rtl/clkloss_pwrdn_ctrl.sv
module clkloss_pwrdn_ctrl #(
  parameter int NUM_CH    = 4,
  parameter int WIN_TICKS = 8,
  parameter int MIN_EDGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_clk,
  input  logic              ref_tick,
  input  logic              pd_pin,
  input  logic              cfg_wr_en,
  input  logic [NUM_CH:0]   cfg_wr_data,
  output logic              pd_global,
  output logic [NUM_CH-1:0] pd_ch,
  output logic              clk_lost
);
  logic              mon_rise;
  logic              win_end;
  logic              det_dis;
  logic [NUM_CH-1:0] ch_off;
  logic              auto_pd;

  clkmon_sync u_sync (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .mon_rise(mon_rise)
  );

  clkmon_window #(.WIN_TICKS(WIN_TICKS), .MIN_EDGES(MIN_EDGES)) u_win (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .mon_rise(mon_rise),
    .win_end(win_end), .clk_lost(clk_lost)
  );

  pd_cfg_reg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .det_dis(det_dis), .ch_off(ch_off)
  );

  assign auto_pd   = clk_lost & ~det_dis;
  assign pd_global = pd_pin | auto_pd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign pd_ch[i] = pd_global | ch_off[i];
  end

  assert_pin_forces_pd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pin |-> (pd_global && (&pd_ch)));

  assert_loss_forces_pd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lost && !det_dis) |-> pd_global);

  assert_disabled_ignores_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (det_dis && !pd_pin) |-> !pd_global);

  assert_global_covers_channels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pd_global |-> (&pd_ch));
endmodule

// File: tb/clkloss_pwrdn_ctrl_tb.sv
module clkloss_pwrdn_ctrl_tb;
  localparam int NUM_CH = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mon_clk = 1'b0;
  logic              ref_tick = 1'b0;
  logic              pd_pin = 1'b0;
  logic              cfg_wr_en = 1'b0;
  logic [NUM_CH:0]   cfg_wr_data = '0;
  logic              pd_global;
  logic [NUM_CH-1:0] pd_ch;
  logic              clk_lost;

  int checks = 0;
  int errors = 0;
  int mon_half = 0;
  int mon_cnt = 0;
  int tick_div = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clkloss_pwrdn_ctrl #(.NUM_CH(NUM_CH), .WIN_TICKS(8), .MIN_EDGES(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .ref_tick(ref_tick),
    .pd_pin(pd_pin), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .pd_global(pd_global), .pd_ch(pd_ch), .clk_lost(clk_lost)
  );

  // reference tick every 4 cycles -> 32-cycle window
  always @(negedge clk) begin
    tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
    ref_tick <= (tick_div == 3);
  end

  // monitored clock: mon_half cycles per level, 0 = stopped
  always @(negedge clk) begin
    if (mon_half == 0) begin
      mon_cnt <= 0;
    end else if (mon_cnt >= mon_half - 1) begin
      mon_cnt <= 0;
      mon_clk <= ~mon_clk;
    end else begin
      mon_cnt <= mon_cnt + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [NUM_CH:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (110) @(negedge clk);
    #1;
  endtask

  // [15:12] half period, [11] pin, [10] det_dis, [9:6] channel bits,
  // [5] exp lost, [4] exp global, [3:0] exp pd_ch
  localparam logic [15:0] VEC [8] = '{
    {4'd2, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0},  // R4 fast clock
    {4'd4, 1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 4'h0},  // R4 exactly at minimum
    {4'd8, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 4'hF},  // R2 R5 slow clock
    {4'd0, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 4'hF},  // R3 stopped clock
    {4'd0, 1'b0, 1'b1, 4'h0, 1'b1, 1'b0, 4'h0},  // R6 disabled detector
    {4'd2, 1'b0, 1'b0, 4'h5, 1'b0, 1'b0, 4'h5},  // R7 per-channel
    {4'd2, 1'b1, 1'b0, 4'h0, 1'b0, 1'b1, 4'hF},  // R1 pin
    {4'd8, 1'b0, 1'b1, 4'hA, 1'b1, 1'b0, 4'hA}   // R6 R7 slow, disabled
  };

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check("R9 clk_lost", clk_lost, 0);
    check("R9 pd_global", pd_global, 0);
    check("R9 pd_ch", pd_ch, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = VEC[i];
      mon_half = int'(v[15:12]);
      pd_pin = v[11];
      wr_cfg({v[9:6], v[10]});
      settle();
      check("R2 clk_lost", clk_lost, v[5]);
      check("R5 pd_global", pd_global, v[4]);
      check("R8 pd_ch", pd_ch, v[3:0]);
    end

    // R1: pin acts combinationally in the same cycle
    pd_pin = 1'b0;
    mon_half = 2;
    wr_cfg('0);
    settle();
    @(negedge clk);
    pd_pin = 1'b1;
    #1;
    check("R1 same-cycle pd_global", pd_global, 1);
    check("R1 same-cycle pd_ch", pd_ch, 4'hF);
    pd_pin = 1'b0;
    #1;
    check("R1 release", pd_global, 0);

    // R3 then R4: loss and automatic recovery
    mon_half = 0;
    settle();
    check("R3 stop lost", clk_lost, 1);
    mon_half = 4;
    settle();
    check("R4 recovered", clk_lost, 0);
    check("R4 recovered pd", pd_global, 0);

    // R7: single channel only
    wr_cfg(5'b01000);
    #1;
    check("R7 channel 2 only", pd_ch, 4'h4);

    // R9: reset mid-run clears register and flag
    mon_half = 0;
    settle();
    check("R3 lost before reset", clk_lost, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 reset clears lost", clk_lost, 0);
    check("R9 reset clears cfg", pd_ch, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule